// File: doc/BRIEF.md
# Monitor Mode Entry Controller

This block makes the one-time decision, as reset lets go, of whether the device starts in its serial monitor mode. It then drives the clocking and watchdog controls that go with that mode. Two routes lead into monitor mode. The first is a high voltage detected on the interrupt pin. The second is an unprogrammed reset vector, with both vector bytes reading all ones. Each route has its own rule for the bus clock divisor and for the watchdog disable.

All inputs are sampled on the first oscillator edge after reset is deasserted. The decision and the divisor choice are then frozen until reset is asserted again. A prescaler on the oscillator clock gives a bus clock enable at one half or one quarter of the oscillator rate. A second counter divides that enable by 256 to give the bit-rate tick for the monitor serial link. From a 9.8304 MHz oscillator with the quarter-rate bus clock, this tick runs at 9600 baud.

Top module: `mon_entry_ctrl`

## Requirements
- R1: While `rstN` is low, `monMode`, `copDisable`, `busClkEn` and `baudTick` are all 0.
- R2: If `irqHvDet` is 1 at the sampling edge, `monMode` becomes 1.
- R3: With `irqHvDet` = 1 and `divSel` = 0 at the sampling edge, `busClkEn` is high on exactly one of every 2 oscillator cycles.
- R4: With `irqHvDet` = 1 and `divSel` = 1 at the sampling edge, `busClkEn` is high on exactly one of every 4 oscillator cycles.
- R5: With `irqHvDet` = 0 and both `vecHi` and `vecLo` equal to 0xFF at the sampling edge, `monMode` becomes 1 and the bus clock uses divide-by-4, whatever the value of `divSel`.
- R6: If only one of the two vector bytes is 0xFF and `irqHvDet` = 0, monitor mode is not entered. A high `rstHvDet` alone does not cause entry either.
- R7: When no entry condition holds, `monMode` and `copDisable` stay 0, the bus clock uses divide-by-4 and `baudTick` never pulses.
- R8: When `irqHvDet` = 1 and both vector bytes are blank at the same time, the high-voltage rules apply: the divisor follows `divSel` and the watchdog disable follows the pins.
- R9: After a high-voltage entry, `copDisable` equals `irqHvDet | rstHvDet` as sampled on the previous oscillator edge.
- R10: After a blank-vector entry, `copDisable` is 1 whatever the values of `irqHvDet` and `rstHvDet`.
- R11: In monitor mode, `baudTick` pulses once every 256 bus clock enables. That is every 512 oscillator cycles at divide-by-2 and every 1024 at divide-by-4.
- R12: Once sampled, the mode and the divisor stay fixed until the next reset. Later changes on `divSel`, `vecHi`, `vecLo` or `irqHvDet` have no effect on them.
- R13: Sampling happens on the first rising `clk` edge at which `rstN` is high, and `monMode` reflects the decision from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator input clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqHvDet | input | 1 | High voltage detected on the interrupt pin |
| rstHvDet | input | 1 | High voltage detected on the reset pin |
| divSel | input | 1 | Divisor select port pin: 0 gives divide-by-2 under high-voltage entry |
| vecHi | input | 8 | Reset vector high byte as read from memory |
| vecLo | input | 8 | Reset vector low byte as read from memory |
| monMode | output | 1 | Monitor mode active |
| busClkEn | output | 1 | One-cycle bus clock enable derived from the oscillator |
| copDisable | output | 1 | Watchdog disable |
| baudTick | output | 1 | Monitor serial bit-rate tick |

## Verification
The bench targets the places where the two entry routes meet:
- Both conditions present at once. A design without the priority would pick divide-by-4 and hold the watchdog off no matter what the pins do.
- Only one vector byte blank. A loose blank check would enter monitor mode.
- A blank vector with `divSel` low. Leaking the select pin into this route would halve the bit period.

After each entry the bench also scrambles the sampled inputs and toggles the high-voltage flags. A design that keeps sampling would change mode or divisor. A design that latches the watchdog disable would fail to release it once both high voltages are removed after a high-voltage entry.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

  typedef enum logic [1:0] {
    ENTRY_NONE  = 2'd0,
    ENTRY_HV    = 2'd1,
    ENTRY_BLANK = 2'd2
  } entryKind_e;

  typedef struct packed {
    logic countEn;
    logic fastDiv;
    logic tickEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/mon_entry_ctl.sv
module mon_entry_ctl
  import mon_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqHvDet,
  input  logic             rstHvDet,
  input  logic             divSel,
  input  logic [VEC_W-1:0] vecHi,
  input  logic [VEC_W-1:0] vecLo,
  output logic             monMode,
  output logic             copDisable,
  output ctrlStrobes_t     strobes
);

  localparam logic [VEC_W-1:0] BLANK_BYTE = {VEC_W{1'b1}};

  logic       sampledQ;
  entryKind_e kindQ;
  entryKind_e kindNext;
  logic       fastQ;
  logic       copQ;
  logic       vecBlank;

  assign vecBlank = (vecHi == BLANK_BYTE) && (vecLo == BLANK_BYTE);

  always_comb begin
    if (irqHvDet)      kindNext = ENTRY_HV;
    else if (vecBlank) kindNext = ENTRY_BLANK;
    else               kindNext = ENTRY_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampledQ <= 1'b0;
      kindQ    <= ENTRY_NONE;
      fastQ    <= 1'b0;
    end else if (!sampledQ) begin
      sampledQ <= 1'b1;
      kindQ    <= kindNext;
      fastQ    <= (kindNext == ENTRY_HV) && !divSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      copQ <= 1'b0;
    end else begin
      case (kindQ)
        ENTRY_HV:    copQ <= irqHvDet | rstHvDet;
        ENTRY_BLANK: copQ <= 1'b1;
        default:     copQ <= 1'b0;
      endcase
    end
  end

  assign monMode         = (kindQ != ENTRY_NONE);
  assign copDisable      = copQ;
  assign strobes.countEn = sampledQ;
  assign strobes.fastDiv = fastQ;
  assign strobes.tickEn  = (kindQ != ENTRY_NONE);

  // R12: the decision is frozen once taken
  a_r12_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    sampledQ |=> ($stable(kindQ) && $stable(fastQ)));

  // R3 / R8: the fast divisor only exists under high-voltage entry
  a_r3_fast_only_hv: assert property (@(posedge clk) disable iff (!rstN)
    fastQ |-> (kindQ == ENTRY_HV));

  // R10: blank entry keeps the watchdog off
  a_r10_blank_cop: assert property (@(posedge clk) disable iff (!rstN)
    (kindQ == ENTRY_BLANK) |=> copDisable);

  // R7: no entry never disables the watchdog
  a_r7_idle_cop: assert property (@(posedge clk) disable iff (!rstN)
    (sampledQ && kindQ == ENTRY_NONE) |=> !copDisable);

endmodule

// File: rtl/mon_entry_dp.sv
module mon_entry_dp
  import mon_entry_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2,
  parameter int BAUD_DIV = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         busClkEn,
  output logic         baudTick
);

  localparam int PRE_W  = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int BAUD_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [PRE_W-1:0]  FAST_LAST = PRE_W'(FAST_DIV - 1);
  localparam logic [PRE_W-1:0]  SLOW_LAST = PRE_W'(SLOW_DIV - 1);
  localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(BAUD_DIV - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLast;
  logic [BAUD_W-1:0] baudCnt;
  logic              baudWrap;

  assign preLast  = strobes.fastDiv ? FAST_LAST : SLOW_LAST;
  assign busClkEn = strobes.countEn && (preCnt == preLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (!strobes.countEn) preCnt <= '0;
    else if (busClkEn)        preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

  assign baudWrap = (baudCnt == BAUD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               baudCnt <= '0;
    else if (!strobes.tickEn) baudCnt <= '0;
    else if (busClkEn)       baudCnt <= baudWrap ? '0 : baudCnt + 1'b1;
  end

  assign baudTick = strobes.tickEn && busClkEn && baudWrap;

  // R3 / R4: enable never lasts two oscillator cycles
  a_r3_en_gap: assert property (@(posedge clk) disable iff (!rstN)
    busClkEn |=> !busClkEn);

  // R11: tick only on a bus clock and only in monitor mode
  a_r11_tick_on_en: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> (busClkEn && strobes.tickEn));

  // R11: ticks are far apart
  a_r11_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2,
  parameter int BAUD_DIV = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqHvDet,
  input  logic             rstHvDet,
  input  logic             divSel,
  input  logic [VEC_W-1:0] vecHi,
  input  logic [VEC_W-1:0] vecLo,
  output logic             monMode,
  output logic             busClkEn,
  output logic             copDisable,
  output logic             baudTick
);

  ctrlStrobes_t strobes;

  mon_entry_ctl #(.VEC_W(VEC_W)) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .irqHvDet   (irqHvDet),
    .rstHvDet   (rstHvDet),
    .divSel     (divSel),
    .vecHi      (vecHi),
    .vecLo      (vecLo),
    .monMode    (monMode),
    .copDisable (copDisable),
    .strobes    (strobes)
  );

  mon_entry_dp #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .BAUD_DIV (BAUD_DIV)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busClkEn (busClkEn),
    .baudTick (baudTick)
  );

  // R1: quiet outputs while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!monMode && !busClkEn && !copDisable && !baudTick));

endmodule

// File: tb/mon_entry_ctrl_tb.sv
`timescale 1ns/1ps
module mon_entry_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       irqHvDet = 1'b0;
  logic       rstHvDet = 1'b0;
  logic       divSel = 1'b0;
  logic [7:0] vecHi = 8'h00;
  logic [7:0] vecLo = 8'h00;
  logic       monMode, busClkEn, copDisable, baudTick;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  mon_entry_ctrl dut_i (
    .clk(clk), .rstN(rstN), .irqHvDet(irqHvDet), .rstHvDet(rstHvDet),
    .divSel(divSel), .vecHi(vecHi), .vecLo(vecLo), .monMode(monMode),
    .busClkEn(busClkEn), .copDisable(copDisable), .baudTick(baudTick)
  );

  function automatic bit expMon(bit irq, logic [7:0] hi, logic [7:0] lo);
    return irq || (hi == 8'hFF && lo == 8'hFF);
  endfunction

  function automatic bit expFast(bit irq, bit sel);
    return irq && !sel;
  endfunction

  function automatic bit expCop(bit irqEntry, bit blankEntry, bit irqNow, bit rstNow);
    if (irqEntry)   return irqNow | rstNow;
    if (blankEntry) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runEntry(bit irq, bit rHv, bit sel, logic [7:0] hi, logic [7:0] lo,
                          string req);
    bit m, f, blankE;
    int cnt;
    int c;
    m = expMon(irq, hi, lo);
    f = expFast(irq, sel);
    blankE = !irq && m;
    @(negedge clk);
    rstN = 1'b0;
    irqHvDet = 1'b1; rstHvDet = 1'b1; divSel = 1'b0;
    vecHi = 8'hFF; vecLo = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1", "monMode in reset", monMode, 0);
    check("R1", "busClkEn in reset", busClkEn, 0);
    check("R1", "copDisable in reset", copDisable, 0);
    check("R1", "baudTick in reset", baudTick, 0);
    irqHvDet = irq; rstHvDet = rHv; divSel = sel; vecHi = hi; vecLo = lo;
    rstN = 1'b1;
    @(negedge clk);
    check("R13", {req, " monMode after sampling edge"}, monMode, m);
    // R12: scramble sampled inputs after the decision
    divSel = 1'($urandom); vecHi = 8'($urandom); vecLo = 8'($urandom);
    irqHvDet = 1'($urandom);
    @(negedge clk);
    check("R12", {req, " monMode held"}, monMode, m);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (busClkEn) cnt++;
    end
    check(f ? "R3" : "R4", {req, " bus enables per 64 cycles"}, cnt, f ? 32 : 16);
    if (m) begin
      c = 0;
      do begin @(negedge clk); c++; end while (!baudTick && c < 2000);
      c = 0;
      do begin @(negedge clk); c++; end while (!baudTick && c < 2000);
      check("R11", {req, " tick period"}, c, f ? 512 : 1024);
    end else begin
      cnt = 0;
      for (int i = 0; i < 1100; i++) begin
        @(negedge clk);
        if (baudTick) cnt++;
      end
      check("R7", {req, " ticks without monitor mode"}, cnt, 0);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      irqHvDet = k[0]; rstHvDet = k[1];
      @(negedge clk);
      check(irq ? "R9" : (blankE ? "R10" : "R7"), {req, " copDisable"},
            copDisable, expCop(irq, blankE, k[0], k[1]));
    end
    check("R12", {req, " monMode still held"}, monMode, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    bit irq, rHv, sel;
    logic [7:0] hi, lo;
    seedDummy = $urandom(32'h5eed);
    repeat (2) @(negedge clk);
    runEntry(1, 0, 0, 8'h12, 8'h34, "R2 hv sel low");
    runEntry(1, 1, 1, 8'h00, 8'h80, "R2 hv sel high");
    runEntry(0, 0, 0, 8'hFF, 8'hFF, "R5 blank sel low");
    runEntry(0, 1, 1, 8'hFF, 8'hFF, "R5 blank rst hv");
    runEntry(0, 0, 0, 8'hFF, 8'hFE, "R6 low byte not blank");
    runEntry(0, 1, 0, 8'h7F, 8'hFF, "R6 high byte not blank");
    runEntry(1, 0, 0, 8'hFF, 8'hFF, "R8 priority sel low");
    runEntry(0, 0, 1, 8'h00, 8'h00, "R7 no entry");
    for (int t = 0; t < 22; t++) begin
      irq = ($urandom % 3) == 0;
      rHv = 1'($urandom);
      sel = 1'($urandom);
      hi  = ($urandom % 2) ? 8'hFF : 8'($urandom);
      lo  = ($urandom % 2) ? 8'hFF : 8'($urandom);
      runEntry(irq, rHv, sel, hi, lo, "random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule